// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block places a small microcontroller core into one of two sleep depths and brings it back out. Software writes a one-byte mode control word. One bit requests a deep halt, and a second bit requests a lighter idle. The sequencer then drives enables for the main oscillator, the core clock, the watchdog, the free-running timer, the brown-out detector, the low-battery detector and the remaining peripherals. The request bits are not stored as readable state. The mode itself is the state, and leaving a mode clears the request that caused it.

Deep halt stops the oscillator and every subsystem. Only a request from the external multi-input wakeup unit ends it. The core is then held for a warm-up interval so the oscillator can settle. The interval is a parameterised cycle count of the always-on reference clock that drives `clk`. Idle keeps the oscillator, watchdog and timer alive and gates everything else. The periodic timer overflow, nominally once every 8192 cycles, ends idle, and the core resumes on the next cycle. After either wake, a resume-pending flag stays set until software writes the power-mode-clear strobe.

Top module: `lpm_seq`

## Requirements
- R1: While reset is low and after it is released, `mode_st` is 00 (run), every enable output is 1 and `resume_pend` is 0.
- R2: In run, a control write with bit 0 of `ctl_wdata` set moves `mode_st` to 01 (halt) after one clock edge, with all enables 0. Bits 7 to 2 of the written value have no effect: a write of 0xFC leaves the block in run.
- R3: In halt, only `wake_req` ends the mode. `tmr_ovf` and control writes leave `mode_st` at 01.
- R4: A `wake_req` in halt moves `mode_st` to 10 (warm-up) for exactly `STARTUP_CYCLES` cycles. During warm-up only `osc_en` is 1. After that the block returns to run.
- R5: In run, a control write with bit 1 set and bit 0 clear moves `mode_st` to 11 (idle). In idle, `osc_en`, `wdt_en` and `tmr_en` are 1, and `core_clk_en`, `bod_en`, `lbd_en` and `periph_en` are 0.
- R6: In idle, `tmr_ovf` returns the block to run, with `core_clk_en` 1, on the very next clock edge. `wake_req` and control writes in idle have no effect.
- R7: A control write with both bit 0 and bit 1 set enters halt, not idle.
- R8: Every return to run from halt warm-up or from idle sets `resume_pend`. It stays set until a `pmc_wr` strobe clears it. A `pmc_wr` while it is clear leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the mode control word |
| ctl_wdata | input | 8 | Control word: bit 0 requests halt, bit 1 requests idle |
| pmc_wr | input | 1 | Power-mode-clear write strobe |
| wake_req | input | 1 | Request from the multi-input wakeup unit |
| tmr_ovf | input | 1 | Overflow pulse from the free-running timer |
| osc_en | output | 1 | Main oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| wdt_en | output | 1 | Watchdog enable |
| tmr_en | output | 1 | Free-running timer enable |
| bod_en | output | 1 | Brown-out detector enable |
| lbd_en | output | 1 | Low-battery detector enable |
| periph_en | output | 1 | Enable for the remaining peripherals |
| mode_st | output | 2 | 00 run, 01 halt, 10 warm-up, 11 idle |
| resume_pend | output | 1 | Set after a wake until the clear strobe |

## Verification
The hardest point to reach is the exact edge where warm-up ends. It only arrives after a halt entry, a wake, and the full count of quiet cycles. The bench enters halt and offers distractor events that the block must ignore. It then wakes the block with a shortened count and samples every warm-up cycle, so that it sees both the last 10 and the first 00. A reset during warm-up then checks that the count and the pending flag are dropped.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: the mode encoding is visible at the top-level status port.
package lpm_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_HALT = 2'b01,
        MODE_WARM = 2'b10,
        MODE_IDLE = 2'b11
    } mode_e;

    typedef struct packed {
        logic osc;
        logic core;
        logic wdt;
        logic tmr;
        logic bod;
        logic lbd;
        logic periph;
    } gate_t;

    localparam int HALT_BIT = 0;
    localparam int IDLE_BIT = 1;
endpackage

// File: rtl/lpm_warmup_timer.sv
// Counts reference cycles while the oscillator settles after a deep-halt wake.
// Assumes: active stays high for the whole warm-up and CYCLES >= 2.
module lpm_warmup_timer #(
    parameter int unsigned CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q;

    assign done = active && (cnt_q == W'(CYCLES - 1));

    // Count while active, hold at the terminal value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < W'(CYCLES))); // R4
endmodule

// File: rtl/lpm_gate_map.sv
// Maps the current power mode to the subsystem enables.
// Assumes: pure decode, and the caller registers the mode.
module lpm_gate_map
    import lpm_pkg::*;
(
    input  mode_e mode,
    output gate_t gates
);
    // Pick which subsystems stay powered in each mode.
    always_comb begin
        gates = '0;
        case (mode)
            MODE_RUN:  gates = '1;
            MODE_HALT: gates = '0;
            MODE_WARM: gates.osc = 1'b1;
            MODE_IDLE: begin
                gates.osc = 1'b1;
                gates.wdt = 1'b1;
                gates.tmr = 1'b1;
            end
            default:   gates = '0;
        endcase
    end
endmodule

// File: rtl/lpm_seq.sv
// Low-power mode sequencer: enters halt or idle on a control write, and
// leaves halt on wakeup plus warm-up, or idle on a timer overflow.
// Assumes: clk is an always-on reference, and control writes only act in run.
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 32768,
    parameter int unsigned CTL_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             pmc_wr,
    input  logic             wake_req,
    input  logic             tmr_ovf,
    output logic             osc_en,
    output logic             core_clk_en,
    output logic             wdt_en,
    output logic             tmr_en,
    output logic             bod_en,
    output logic             lbd_en,
    output logic             periph_en,
    output logic [1:0]       mode_st,
    output logic             resume_pend
);
    mode_e state_q, state_d;
    logic  pend_q;
    logic  warm_done;
    logic  resume;
    gate_t gates;

    lpm_warmup_timer #(.CYCLES(STARTUP_CYCLES)) u_warm (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == MODE_WARM),
        .done   (warm_done)
    );

    lpm_gate_map u_gates (
        .mode  (state_q),
        .gates (gates)
    );

    // Next-mode selection. Halt beats idle when both bits are written.
    always_comb begin
        state_d = state_q;
        case (state_q)
            MODE_RUN: begin
                if (ctl_wr && ctl_wdata[HALT_BIT])      state_d = MODE_HALT;
                else if (ctl_wr && ctl_wdata[IDLE_BIT]) state_d = MODE_IDLE;
            end
            MODE_HALT: if (wake_req)  state_d = MODE_WARM;
            MODE_WARM: if (warm_done) state_d = MODE_RUN;
            MODE_IDLE: if (tmr_ovf)   state_d = MODE_RUN;
            default:                  state_d = MODE_RUN;
        endcase
    end

    assign resume = (state_q != MODE_RUN) && (state_d == MODE_RUN);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_RUN;
        else        state_q <= state_d;
    end

    // Resume-pending flag: set on any wake, cleared by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (resume) pend_q <= 1'b1;
        else if (pmc_wr) pend_q <= 1'b0;
    end

    assign osc_en      = gates.osc;
    assign core_clk_en = gates.core;
    assign wdt_en      = gates.wdt;
    assign tmr_en      = gates.tmr;
    assign bod_en      = gates.bod;
    assign lbd_en      = gates.lbd;
    assign periph_en   = gates.periph;
    assign mode_st     = state_q;
    assign resume_pend = pend_q;

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HALT && !wake_req) |=> (state_q == MODE_HALT)); // R3
    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HALT && wake_req) |=> (state_q == MODE_WARM)); // R4
    AST_WARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_WARM && !warm_done) |=> (state_q == MODE_WARM)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_IDLE && !tmr_ovf) |=> (state_q == MODE_IDLE)); // R6
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_IDLE && tmr_ovf) |=> (mode_st == 2'b00 && core_clk_en)); // R6
    AST_BOTH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_RUN && ctl_wr && ctl_wdata[HALT_BIT]) |=> (mode_st == 2'b01)); // R7
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_IDLE && tmr_ovf) || (state_q == MODE_WARM && warm_done))
        |=> resume_pend); // R8
endmodule

// File: tb/lpm_seq_test.sv
`timescale 1ns/1ps
module lpm_seq_test;
    localparam int unsigned SC = 12;
    localparam int NV = 12;

    // Vector layout: wr | data[7:0] | pmc | wake | ovf | mode[1:0] | pend | gates[6:0]
    // Gates order: osc core wdt tmr bod lbd periph
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 8'hFC, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 7'h7F}, // R2 upper bits ignored
        {1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 7'h58}, // R5 enter idle
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 7'h58}, // R6 wake ignored
        {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 7'h58}, // R6 write ignored
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 7'h7F}, // R6 overflow resumes
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 7'h7F}, // R8 clear
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 7'h7F}, // R8 clear when clear
        {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 7'h00}, // R2 enter halt
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 7'h00}, // R3 overflow ignored
        {1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 7'h00}, // R3 write ignored
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 7'h00}, // R3 hold
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 7'h40}  // R4 wake to warm-up
    };
    string vreq [NV] = '{"R2", "R5", "R6", "R6", "R6", "R8",
                         "R8", "R2", "R3", "R3", "R3", "R4"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       pmc_wr = 1'b0;
    logic       wake_req = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       osc_en, core_clk_en, wdt_en, tmr_en, bod_en, lbd_en, periph_en;
    logic [1:0] mode_st;
    logic       resume_pend;
    int         checks = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    lpm_seq #(.STARTUP_CYCLES(SC)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .pmc_wr(pmc_wr), .wake_req(wake_req), .tmr_ovf(tmr_ovf),
        .osc_en(osc_en), .core_clk_en(core_clk_en), .wdt_en(wdt_en),
        .tmr_en(tmr_en), .bod_en(bod_en), .lbd_en(lbd_en),
        .periph_en(periph_en), .mode_st(mode_st), .resume_pend(resume_pend)
    );

    // Drive one cycle of inputs at a falling edge and return at the next falling edge.
    task automatic cyc(input logic wr, input logic [7:0] d, input logic pmc,
                       input logic wk, input logic ov);
        ctl_wr = wr; ctl_wdata = d; pmc_wr = pmc; wake_req = wk; tmr_ovf = ov;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = '0; pmc_wr = 1'b0; wake_req = 1'b0; tmr_ovf = 1'b0;
    endtask

    task automatic chk(input string req, input logic [1:0] m, input logic p,
                       input logic [6:0] g);
        logic [9:0] act, exp;
        act = {mode_st, resume_pend,
               osc_en, core_clk_en, wdt_en, tmr_en, bod_en, lbd_en, periph_en};
        exp = {m, p, g};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: mode/pend/gates actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1", 2'b00, 1'b0, 7'h7F);  // during reset
        rst_n = 1'b1;
        cyc(0, 8'h00, 0, 0, 0);
        chk("R1", 2'b00, 1'b0, 7'h7F);  // after release

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11], VEC[i][10]);
            chk(vreq[i], VEC[i][9:8], VEC[i][7], VEC[i][6:0]);
        end

        // Warm-up has lasted one cycle so far. It must hold for SC cycles in total.
        for (int i = 1; i < SC; i++) begin
            cyc(0, 8'h00, 0, 0, 1);
            chk("R4", 2'b10, 1'b0, 7'h40);
        end
        cyc(0, 8'h00, 0, 0, 0);
        chk("R4", 2'b00, 1'b1, 7'h7F);   // R8: pending after halt wake
        cyc(0, 8'h00, 0, 0, 0);
        chk("R8", 2'b00, 1'b1, 7'h7F);   // stays set without a clear
        cyc(0, 8'h00, 1, 0, 0);
        chk("R8", 2'b00, 1'b0, 7'h7F);

        cyc(1, 8'h03, 0, 0, 0);
        chk("R7", 2'b01, 1'b0, 7'h00);
        cyc(0, 8'h00, 0, 1, 0);
        chk("R4", 2'b10, 1'b0, 7'h40);

        // Reset in the middle of warm-up returns to run with no pending flag.
        rst_n = 1'b0;
        cyc(0, 8'h00, 0, 0, 0);
        chk("R1", 2'b00, 1'b0, 7'h7F);
        rst_n = 1'b1;
        cyc(1, 8'h02, 0, 0, 0);
        chk("R5", 2'b11, 1'b0, 7'h58);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule